// File: doc/BRIEF.md
# Prescaled Pacer Clock Generator

This block produces the periodic pacing strobe that starts conversions in a data-acquisition front end. It runs on the 4 MHz reference clock, so one clock cycle is 250 ns. The reference is first divided by a power of two chosen by a 4-bit prescale code. The result is then divided by an 8-bit count. A one-cycle `tick` is raised at the end of every resulting period.

Both settings live in one 16-bit timer control word. Software writes it through a simple write strobe and can read it back at any time. The count field is stored inverted: software writes 255 minus the count it wants. A separate enable input gates the pacing. While the enable is low, no tick is produced and both internal counters are held at zero. A board-initialise strobe puts the control word back to its power-up value.

Top module: `pacer_clock_gen`

## Requirements
- R1: After reset the control word reads 0xF000 and `tick` is low.
- R2: A write with `wrEn` stores `wrData[11:0]`. Bits 15:12 always read as ones, whatever was written to them. The stored value is visible on `rdData` in the cycle after the write edge.
- R3: `boardInit` restores the control word to 0xF000, so the upper byte reads 0xF0. It takes priority over a write in the same cycle.
- R4: The count field occupies bits 7:0 and holds 255 minus the count N. The tick period is N times the prescaled base period, measured in reference clock cycles.
- R5: A count field of 255, which means N = 0, is treated as N = 1. The tick therefore never stops.
- R6: The prescale code p occupies bits 11:8. Codes 0 and 1 both divide by one. A code p of 2 or more divides by 2^p, up to 2^15 for code 15.
- R7: `tick` is high for exactly one cycle per period, and successive ticks are exactly one period apart. When the period is one cycle, `tick` stays high on every cycle.
- R8: A write or a board-initialise reloads both counters on that clock edge. The first new tick is high in the period-th cycle after that edge.
- R9: While `clkEn` is low, `tick` stays low and both counters clear. After `clkEn` rises, the first tick comes in the period-th cycle with `clkEn` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| boardInit | input | 1 | Restores the control word to its power-up value |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 16 | Control word to store |
| clkEn | input | 1 | Enables pacing; while low, clears the counters |
| rdData | output | 16 | Current control word |
| tick | output | 1 | One-cycle pacing pulse at each period boundary |

## Verification
A table of control words is applied, and for each one the bench measures the distance from the write to the first tick and from that tick to the next. The entries pair each prescale code with several counts. This separates the two divide stages and exposes a mistake in either one. Further entries cover the equal behaviour of prescale codes 0 and 1, the inverted count encoding at both ends (field 0 and field 255), and the deepest prescale code. Directed cases then cover a rewrite in the middle of a period, a pause of the enable, and a board-initialise that collides with a write. These show whether the counters really restart rather than carry on.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;     // settings changed: restart counting from zero
    logic clear;    // pacing disabled: hold counters at zero
    logic advance;  // count one reference cycle
  } pacerStrobe_t;

endpackage

// File: rtl/pacer_ctrl.sv
module pacer_ctrl
  import pacer_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int PRESC_W = 4,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               boardInit,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic               clkEn,
  output logic [REG_W-1:0]   regVal,
  output logic [PRESC_W-1:0] prescCode,
  output logic [DIV_W-1:0]   divField,
  output pacerStrobe_t       strobe
);

  localparam int FIELD_W = PRESC_W + DIV_W;
  localparam int PAD_W   = REG_W - FIELD_W;

  logic [FIELD_W-1:0] fieldReg;

  // Control word: board-initialise takes priority over a write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldReg <= '0;
    end else if (boardInit) begin
      fieldReg <= '0;
    end else if (wrEn) begin
      fieldReg <= wrData[FIELD_W-1:0];
    end
  end

  // Unused upper bits read as ones
  assign regVal    = {{PAD_W{1'b1}}, fieldReg};
  assign prescCode = fieldReg[FIELD_W-1:DIV_W];
  assign divField  = fieldReg[DIV_W-1:0];

  always_comb begin
    strobe.load    = boardInit | wrEn;
    strobe.clear   = ~clkEn;
    strobe.advance = clkEn & ~(boardInit | wrEn);
  end

  // R2: a plain write lands in the control word
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !boardInit) |=> (regVal[FIELD_W-1:0] == $past(wrData[FIELD_W-1:0])));

  // R3: initialise wins over a simultaneous write
  a_r3_init_wins: assert property (@(posedge clk) disable iff (!rstN)
    boardInit |=> (prescCode == '0 && divField == '0));

  // R8: never restart and advance in the same cycle
  a_r8_load_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.advance}));

endmodule

// File: rtl/pacer_datapath.sv
module pacer_datapath
  import pacer_pkg::*;
#(
  parameter int PRESC_W = 4,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  pacerStrobe_t       strobe,
  input  logic [PRESC_W-1:0] prescCode,
  input  logic [DIV_W-1:0]   divField,
  input  logic               clkEn,
  output logic               tick
);

  localparam int PRE_W = (1 << PRESC_W) - 1;
  localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};

  logic [PRE_W:0]   preWide;
  logic [PRE_W-1:0] preLimit;
  logic [DIV_W-1:0] divCount;
  logic [DIV_W-1:0] divLimit;
  logic [PRE_W-1:0] preCnt;
  logic [DIV_W-1:0] divCnt;
  logic             preTerm;
  logic             divTerm;

  // Prescale decode: codes 0 and 1 both mean divide by one
  always_comb begin
    preWide = (PRE_W+1)'(1) << prescCode;
    if (prescCode <= PRESC_W'(1)) begin
      preLimit = '0;
    end else begin
      preLimit = PRE_W'(preWide - (PRE_W+1)'(1));
    end
  end

  // Count decode: inverted field, zero count promoted to one
  always_comb begin
    divCount = DIV_MAX - divField;
    divLimit = (divCount == '0) ? '0 : divCount - DIV_W'(1);
  end

  assign preTerm = (preCnt == preLimit);
  assign divTerm = (divCnt == divLimit);
  assign tick    = clkEn & preTerm & divTerm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (strobe.load || strobe.clear) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (strobe.advance) begin
      if (preTerm) begin
        preCnt <= '0;
        divCnt <= divTerm ? '0 : divCnt + DIV_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  // R4: count stage stays within the programmed count
  a_r4_div_bound: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= divLimit);

  // R6: prescale stage stays within the programmed ratio
  a_r6_pre_bound: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preLimit);

  // R9: disabling pacing leaves both stages at zero
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (preCnt == '0 && divCnt == '0));

endmodule

// File: rtl/pacer_clock_gen.sv
module pacer_clock_gen
  import pacer_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int PRESC_W = 4,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             boardInit,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             clkEn,
  output logic [REG_W-1:0] rdData,
  output logic             tick
);

  pacerStrobe_t       strobe;
  logic [PRESC_W-1:0] prescCode;
  logic [DIV_W-1:0]   divField;

  pacer_ctrl #(.REG_W(REG_W), .PRESC_W(PRESC_W), .DIV_W(DIV_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .boardInit (boardInit),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .clkEn     (clkEn),
    .regVal    (rdData),
    .prescCode (prescCode),
    .divField  (divField),
    .strobe    (strobe)
  );

  pacer_datapath #(.PRESC_W(PRESC_W), .DIV_W(DIV_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .prescCode (prescCode),
    .divField  (divField),
    .clkEn     (clkEn),
    .tick      (tick)
  );

endmodule

// File: tb/test_pacer_clock_gen.sv
`timescale 1ns/1ps
module test_pacer_clock_gen;

  localparam int CLK_PERIOD = 250;
  localparam int WATCHDOG   = 190000;
  localparam int NVEC       = 10;

  typedef struct packed {
    logic [15:0] val;
    logic [31:0] period;
  } vec_t;

  // Control word, expected period in reference cycles
  localparam vec_t VECS [NVEC] = '{
    '{16'h0000, 32'd255},    // R4 field 0 -> count 255
    '{16'h00FE, 32'd1},      // R4 count 1
    '{16'h00FD, 32'd2},      // R4 count 2
    '{16'h01FD, 32'd2},      // R6 code 1 same as code 0
    '{16'h02FD, 32'd8},      // R6 code 2
    '{16'h03F0, 32'd120},    // R6 code 3, count 15
    '{16'h00FF, 32'd1},      // R5 count 0 -> 1
    '{16'h04FF, 32'd16},     // R5 with prescale
    '{16'h05C8, 32'd1760},   // R4 count 55, code 5
    '{16'h0FFE, 32'd32768}   // R6 deepest prescale
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        boardInit = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        clkEn = 1'b0;
  logic [15:0] rdData;
  logic        tick;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pacer_clock_gen i_pacer_clock_gen (
    .clk(clk), .rstN(rstN), .boardInit(boardInit), .wrEn(wrEn),
    .wrData(wrData), .clkEn(clkEn), .rdData(rdData), .tick(tick)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [15:0] v);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Called in cycle 1 after a restart edge
  task automatic measure(input int expPeriod, input string req);
    int k;
    int g;
    #1;
    k = 1;
    while (!tick && k < 40000) begin
      @(negedge clk);
      #1;
      k++;
    end
    check(k == expPeriod, {req, " first tick"}, k, expPeriod);
    @(negedge clk);
    #1;
    g = 1;
    while (!tick && g < 40000) begin
      @(negedge clk);
      #1;
      g++;
    end
    check(g == expPeriod, {req, " R7 spacing"}, g, expPeriod);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(rdData == 16'hF000, "R1 reset word", rdData, 16'hF000);
    check(tick == 1'b0, "R1 reset tick", tick, 0);

    clkEn = 1'b1;
    foreach (VECS[i]) begin
      writeReg(VECS[i].val);
      #1;
      check(rdData == (16'hF000 | (VECS[i].val & 16'h0FFF)), "R2 readback",
            rdData, 16'hF000 | (VECS[i].val & 16'h0FFF));
      measure(int'(VECS[i].period), "R4/R6 table");
    end

    // R2: upper bits ignored
    writeReg(16'hABCD);
    #1;
    check(rdData == 16'hFBCD, "R2 pad ones", rdData, 16'hFBCD);

    // R3: initialise collides with a write
    @(negedge clk);
    boardInit = 1'b1;
    wrEn = 1'b1;
    wrData = 16'h0ABC;
    @(negedge clk);
    boardInit = 1'b0;
    wrEn = 1'b0;
    #1;
    check(rdData == 16'hF000, "R3 init wins", rdData, 16'hF000);
    check(rdData[15:8] == 8'hF0, "R3 upper byte", rdData[15:8], 8'hF0);
    measure(255, "R3 init restart");

    // R8: rewrite in mid-period restarts counting
    writeReg(16'h00F5);
    repeat (5) @(negedge clk);
    writeReg(16'h00F5);
    measure(10, "R8 reload");

    // R9: enable low holds tick low, then restart
    begin
      int seen;
      @(negedge clk);
      clkEn = 1'b0;
      seen = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        #1;
        if (tick) seen++;
      end
      check(seen == 0, "R9 disabled tick", seen, 0);
      @(negedge clk);
      clkEn = 1'b1;
      measure(10, "R9 re-enable");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule